// File: doc/BRIEF.md
# Time-of-day and date alarm comparator

This block takes the running clock and calendar of a real-time clock and checks them against two alarm configuration words: one for the time of day and one for the date. The current seconds, minutes, hour, AM/PM flag, month and day of month come in as BCD. Each alarm field has its own enable bit, so an alarm can name a single field, such as "every minute at second 30", or a full date and time.

On every per-second update strobe the block compares the fields. When at least one field is enabled and every enabled field equals the current value, it raises a one-cycle alarm strobe. It also checks each alarm word on every cycle and drives one flag for each word whose enabled fields hold an illegal BCD value. While either word is flagged, no alarm fires. The hour compare takes account of a 12-hour/24-hour mode input.

Top module: `rtc_alarm_match`

## Requirements
- R1: While reset is high, and in the first cycle after it, `alarm_pulse`, `time_cfg_bad` and `date_cfg_bad` are 0.
- R2: The time word holds seconds in bits 6:0 (enable bit 7), minutes in bits 14:8 (enable bit 15), the hour in bits 21:16, AM/PM at bit 22 (1 = PM) and the hour enable at bit 23. The date word holds the month in bits 20:16 (enable bit 23) and the day of month in bits 29:24 (enable bit 31). All other bits are ignored.
- R3: `alarm_pulse` is high for exactly the one cycle after a cycle in which `sec_tick` is high and every enabled field equals its current value. Without `sec_tick` it stays low.
- R4: If no enable bit is set in either word, `alarm_pulse` never rises.
- R5: A disabled field takes no part in the compare, so a mismatch there does not block the alarm.
- R6: When `mode_12h` is 1, the hour matches only if both the hour value and the AM/PM bit equal the current ones. When `mode_12h` is 0, the AM/PM bits are ignored.
- R7: An enabled seconds or minutes field whose low nibble is above 9, or whose value is above BCD 59, sets `time_cfg_bad` one cycle later.
- R8: An enabled hour field is legal only for BCD 00 to 23 when `mode_12h` is 0, and for BCD 01 to 12 when `mode_12h` is 1. Any other value sets `time_cfg_bad` one cycle later.
- R9: An enabled month outside BCD 01 to 12, or an enabled day of month outside BCD 01 to 31 (a low nibble above 9 included), sets `date_cfg_bad` one cycle later.
- R10: While either word holds an illegal enabled field, no alarm is produced, even if the raw field values equal the current ones.
- R11: An illegal value in a disabled field does not set either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sec_tick | input | 1 | One-cycle strobe each time the clock advances a second |
| mode_12h | input | 1 | 1 = 12-hour mode with AM/PM, 0 = 24-hour mode |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hour, BCD |
| cur_pm | input | 1 | Current AM/PM, 1 = PM |
| cur_month | input | 5 | Current month, BCD |
| cur_date | input | 6 | Current day of month, BCD |
| time_alarm_cfg | input | 32 | Time alarm word |
| date_alarm_cfg | input | 32 | Date alarm word |
| alarm_pulse | output | 1 | One-cycle alarm strobe |
| time_cfg_bad | output | 1 | Time alarm word holds an illegal enabled field |
| date_cfg_bad | output | 1 | Date alarm word holds an illegal enabled field |

## Verification
All three outputs are registered one stage after the inputs they depend on. `alarm_pulse` therefore appears in the cycle after `sec_tick`, and both validity flags follow a configuration change by exactly one cycle. The bench drives inputs on the falling edge. At each rising edge a behavioural model computes the expected outputs from those inputs, working on decimal values, and holds them. The design outputs are compared with these held values at the next falling edge, so each comparison lands on the cycle in which the result is due.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  // Width of each configuration word
  localparam int WORD_W = 32;
  // BCD field widths
  localparam int SEC_W  = 7;
  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int MON_W  = 5;
  localparam int DATE_W = 6;
  // Field positions, fixed because software packs these words
  localparam int SEC_LSB   = 0;
  localparam int SEC_EN    = 7;
  localparam int MIN_LSB   = 8;
  localparam int MIN_EN    = 15;
  localparam int HOUR_LSB  = 16;
  localparam int PM_BIT    = 22;
  localparam int HOUR_EN   = 23;
  localparam int MON_LSB   = 16;
  localparam int MON_EN    = 23;
  localparam int DATE_LSB  = 24;
  localparam int DATE_EN   = 31;
  // Compare lanes: sec, min, hour(+pm), month, date
  localparam int NFIELD    = 5;
  localparam int LANE_W    = 8;
  localparam int L_SEC = 0, L_MIN = 1, L_HOUR = 2, L_MON = 3, L_DATE = 4;
endpackage

// File: rtl/rtc_alarm_field_valid.sv
module rtc_alarm_field_valid #(
  parameter int          W  = 7,
  parameter logic [7:0]  LO = 8'h00,
  parameter logic [7:0]  HI = 8'h59
) (
  input  logic [W-1:0] val,
  input  logic         en,
  output logic         bad
);
  localparam int PADW = 8 - W;
  logic [7:0] v8;
  logic       digits_ok;
  logic       range_ok;

  assign v8        = {{PADW{1'b0}}, val};
  assign digits_ok = (v8[3:0] <= 4'd9) && (v8[7:4] <= 4'd9);
  assign range_ok  = (v8 >= LO) && (v8 <= HI);
  assign bad       = en && !(digits_ok && range_ok);
endmodule

// File: rtl/rtc_alarm_field_cmp.sv
module rtc_alarm_field_cmp #(
  parameter int NF = 5,
  parameter int LW = 8
) (
  input  logic [NF-1:0]         f_en,
  input  logic [NF-1:0][LW-1:0] f_alm,
  input  logic [NF-1:0][LW-1:0] f_cur,
  output logic                  any_en,
  output logic                  all_match
);
  logic [NF-1:0] lane_ok;

  for (genvar g = 0; g < NF; g++) begin : g_lane
    assign lane_ok[g] = !f_en[g] || (f_alm[g] == f_cur[g]);
  end

  assign any_en    = |f_en;
  assign all_match = &lane_ok;
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              mode_12h,
  input  logic [SEC_W-1:0]  cur_sec,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic              cur_pm,
  input  logic [MON_W-1:0]  cur_month,
  input  logic [DATE_W-1:0] cur_date,
  input  logic [WORD_W-1:0] time_alarm_cfg,
  input  logic [WORD_W-1:0] date_alarm_cfg,
  output logic              alarm_pulse,
  output logic              time_cfg_bad,
  output logic              date_cfg_bad
);
  // Field extraction
  logic [SEC_W-1:0]  a_sec;
  logic [MIN_W-1:0]  a_min;
  logic [HOUR_W-1:0] a_hour;
  logic [MON_W-1:0]  a_mon;
  logic [DATE_W-1:0] a_date;
  logic a_pm, e_sec, e_min, e_hour, e_mon, e_date;

  assign a_sec  = time_alarm_cfg[SEC_LSB  +: SEC_W];
  assign a_min  = time_alarm_cfg[MIN_LSB  +: MIN_W];
  assign a_hour = time_alarm_cfg[HOUR_LSB +: HOUR_W];
  assign a_pm   = time_alarm_cfg[PM_BIT];
  assign e_sec  = time_alarm_cfg[SEC_EN];
  assign e_min  = time_alarm_cfg[MIN_EN];
  assign e_hour = time_alarm_cfg[HOUR_EN];
  assign a_mon  = date_alarm_cfg[MON_LSB  +: MON_W];
  assign a_date = date_alarm_cfg[DATE_LSB +: DATE_W];
  assign e_mon  = date_alarm_cfg[MON_EN];
  assign e_date = date_alarm_cfg[DATE_EN];

  // Entry validity
  logic sec_bad, min_bad, h24_bad, h12_bad, mon_bad, date_bad;
  logic hour_bad, time_bad_c, date_bad_c;

  rtc_alarm_field_valid #(.W(SEC_W),  .LO(8'h00), .HI(8'h59)) u_v_sec
    (.val(a_sec),  .en(e_sec),  .bad(sec_bad));
  rtc_alarm_field_valid #(.W(MIN_W),  .LO(8'h00), .HI(8'h59)) u_v_min
    (.val(a_min),  .en(e_min),  .bad(min_bad));
  rtc_alarm_field_valid #(.W(HOUR_W), .LO(8'h00), .HI(8'h23)) u_v_h24
    (.val(a_hour), .en(e_hour), .bad(h24_bad));
  rtc_alarm_field_valid #(.W(HOUR_W), .LO(8'h01), .HI(8'h12)) u_v_h12
    (.val(a_hour), .en(e_hour), .bad(h12_bad));
  rtc_alarm_field_valid #(.W(MON_W),  .LO(8'h01), .HI(8'h12)) u_v_mon
    (.val(a_mon),  .en(e_mon),  .bad(mon_bad));
  rtc_alarm_field_valid #(.W(DATE_W), .LO(8'h01), .HI(8'h31)) u_v_date
    (.val(a_date), .en(e_date), .bad(date_bad));

  assign hour_bad   = mode_12h ? h12_bad : h24_bad;
  assign time_bad_c = sec_bad | min_bad | hour_bad;
  assign date_bad_c = mon_bad | date_bad;

  // Compare lanes
  logic [NFIELD-1:0]             f_en;
  logic [NFIELD-1:0][LANE_W-1:0] f_alm;
  logic [NFIELD-1:0][LANE_W-1:0] f_cur;
  logic any_en, all_match;

  always_comb begin
    f_en          = '0;
    f_en[L_SEC]   = e_sec;
    f_en[L_MIN]   = e_min;
    f_en[L_HOUR]  = e_hour;
    f_en[L_MON]   = e_mon;
    f_en[L_DATE]  = e_date;
    f_alm         = '0;
    f_cur         = '0;
    f_alm[L_SEC]  = LANE_W'(a_sec);
    f_cur[L_SEC]  = LANE_W'(cur_sec);
    f_alm[L_MIN]  = LANE_W'(a_min);
    f_cur[L_MIN]  = LANE_W'(cur_min);
    f_alm[L_HOUR] = LANE_W'({a_pm & mode_12h, a_hour});
    f_cur[L_HOUR] = LANE_W'({cur_pm & mode_12h, cur_hour});
    f_alm[L_MON]  = LANE_W'(a_mon);
    f_cur[L_MON]  = LANE_W'(cur_month);
    f_alm[L_DATE] = LANE_W'(a_date);
    f_cur[L_DATE] = LANE_W'(cur_date);
  end

  rtc_alarm_field_cmp #(.NF(NFIELD), .LW(LANE_W)) u_cmp (
    .f_en     (f_en),
    .f_alm    (f_alm),
    .f_cur    (f_cur),
    .any_en   (any_en),
    .all_match(all_match)
  );

  logic fire;
  assign fire = sec_tick && any_en && all_match && !time_bad_c && !date_bad_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      alarm_pulse  <= 1'b0;
      time_cfg_bad <= 1'b0;
      date_cfg_bad <= 1'b0;
    end else begin
      alarm_pulse  <= fire;
      time_cfg_bad <= time_bad_c;
      date_cfg_bad <= date_bad_c;
    end
  end
endmodule

// File: rtl/rtc_alarm_match_chk.sv
module rtc_alarm_match_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              sec_tick,
  input logic              mode_12h,
  input logic [SEC_W-1:0]  cur_sec,
  input logic              cur_pm,
  input logic [WORD_W-1:0] time_alarm_cfg,
  input logic [WORD_W-1:0] date_alarm_cfg,
  input logic              alarm_pulse,
  input logic              time_cfg_bad,
  input logic              date_cfg_bad
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !alarm_pulse && !time_cfg_bad && !date_cfg_bad);

  // R3
  pulse_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse |-> $past(sec_tick));

  // R4
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse |-> $past(time_alarm_cfg[SEC_EN] | time_alarm_cfg[MIN_EN] |
                          time_alarm_cfg[HOUR_EN] | date_alarm_cfg[MON_EN] |
                          date_alarm_cfg[DATE_EN]));

  // R10
  pulse_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse |-> !time_cfg_bad && !date_cfg_bad);

  // R6
  pm_match_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse && $past(time_alarm_cfg[HOUR_EN]) && $past(mode_12h)
      |-> $past(cur_pm) == $past(time_alarm_cfg[PM_BIT]));

  // R5
  sec_match_chk: assert property (@(posedge clk) disable iff (rst)
    alarm_pulse && $past(time_alarm_cfg[SEC_EN])
      |-> $past(cur_sec) == $past(time_alarm_cfg[SEC_LSB +: SEC_W]));
endmodule

bind rtc_alarm_match rtc_alarm_match_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick), .mode_12h(mode_12h),
  .cur_sec(cur_sec), .cur_pm(cur_pm),
  .time_alarm_cfg(time_alarm_cfg), .date_alarm_cfg(date_alarm_cfg),
  .alarm_pulse(alarm_pulse), .time_cfg_bad(time_cfg_bad),
  .date_cfg_bad(date_cfg_bad)
);

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sec_tick = 1'b0;
  logic mode_12h = 1'b0;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic       cur_pm = 1'b0;
  logic [4:0] cur_month = 5'h01;
  logic [5:0] cur_date = 6'h01;
  logic [31:0] tcfg = '0;
  logic [31:0] dcfg = '0;
  logic alarm_pulse, time_cfg_bad, date_cfg_bad;

  int vectors = 0;
  int errors = 0;
  int alarms_expected = 0;
  string tag = "R1";
  string exp_tag = "R1";
  bit exp_alarm = 1'b0, exp_tbad = 1'b0, exp_dbad = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .mode_12h(mode_12h),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_pm(cur_pm),
    .cur_month(cur_month), .cur_date(cur_date),
    .time_alarm_cfg(tcfg), .date_alarm_cfg(dcfg),
    .alarm_pulse(alarm_pulse), .time_cfg_bad(time_cfg_bad),
    .date_cfg_bad(date_cfg_bad)
  );

  // Decimal view of a BCD value, legal when both digits are decimal and in range
  function automatic bit bcd_in(int v, int lo, int hi);
    int d;
    if ((v % 16) > 9 || (v / 16) > 9) return 1'b0;
    d = (v / 16) * 10 + (v % 16);
    return (d >= lo) && (d <= hi);
  endfunction

  function automatic bit model_tbad(logic [31:0] w, bit m12);
    bit b = 1'b0;
    if (w[7]  && !bcd_in(int'(w[6:0]), 0, 59)) b = 1'b1;
    if (w[15] && !bcd_in(int'(w[14:8]), 0, 59)) b = 1'b1;
    if (w[23]) begin
      if (m12 && !bcd_in(int'(w[21:16]), 1, 12)) b = 1'b1;
      if (!m12 && !bcd_in(int'(w[21:16]), 0, 23)) b = 1'b1;
    end
    return b;
  endfunction

  function automatic bit model_dbad(logic [31:0] w);
    bit b = 1'b0;
    if (w[23] && !bcd_in(int'(w[20:16]), 1, 12)) b = 1'b1;
    if (w[31] && !bcd_in(int'(w[29:24]), 1, 31)) b = 1'b1;
    return b;
  endfunction

  function automatic bit model_fire();
    bit ok;
    if (!sec_tick) return 1'b0;
    if (!(tcfg[7] || tcfg[15] || tcfg[23] || dcfg[23] || dcfg[31])) return 1'b0;
    if (model_tbad(tcfg, mode_12h) || model_dbad(dcfg)) return 1'b0;
    ok = 1'b1;
    if (tcfg[7]  && tcfg[6:0]   != cur_sec)   ok = 1'b0;
    if (tcfg[15] && tcfg[14:8]  != cur_min)   ok = 1'b0;
    if (tcfg[23] && tcfg[21:16] != cur_hour)  ok = 1'b0;
    if (tcfg[23] && mode_12h && tcfg[22] != cur_pm) ok = 1'b0;
    if (dcfg[23] && dcfg[20:16] != cur_month) ok = 1'b0;
    if (dcfg[31] && dcfg[29:24] != cur_date)  ok = 1'b0;
    return ok;
  endfunction

  // Reference model: registered one cycle like the requirements demand
  always @(posedge clk) begin
    exp_tag <= tag;
    if (rst) begin
      exp_alarm <= 1'b0; exp_tbad <= 1'b0; exp_dbad <= 1'b0;
    end else begin
      exp_alarm <= model_fire();
      exp_tbad  <= model_tbad(tcfg, mode_12h);
      exp_dbad  <= model_dbad(dcfg);
      if (model_fire()) alarms_expected <= alarms_expected + 1;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    vectors++;
    if (alarm_pulse !== exp_alarm) begin
      errors++;
      $display("FAIL %s alarm_pulse actual=%b expected=%b t=%0t", exp_tag, alarm_pulse, exp_alarm, $time);
    end
    if (time_cfg_bad !== exp_tbad) begin
      errors++;
      $display("FAIL %s time_cfg_bad actual=%b expected=%b t=%0t", exp_tag, time_cfg_bad, exp_tbad, $time);
    end
    if (date_cfg_bad !== exp_dbad) begin
      errors++;
      $display("FAIL %s date_cfg_bad actual=%b expected=%b t=%0t", exp_tag, date_cfg_bad, exp_dbad, $time);
    end
  end

  function automatic logic [31:0] tw(logic [6:0] s, bit se, logic [6:0] m, bit me,
                                     logic [5:0] h, bit pm, bit he);
    return {8'h00, he, pm, h, me, m, se, s};
  endfunction

  function automatic logic [31:0] dw(logic [4:0] mo, bit moe, logic [5:0] d, bit de);
    return {de, 1'b0, d, moe, 2'b00, mo, 16'h0000};
  endfunction

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_tick(string t);
    tag = t;
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    // R1: reset with illegal words present, outputs must stay low
    tag = "R1";
    tcfg = tw(7'h7F, 1, 7'h00, 0, 6'h00, 0, 0);
    dcfg = dw(5'h00, 1, 6'h00, 0);
    sec_tick = 1'b1;
    idle(4);
    rst = 1'b0; sec_tick = 1'b0;
    tcfg = '0; dcfg = '0;
    idle(2);

    // R3: seconds-only alarm, tick present and absent
    cur_sec = 7'h30; cur_min = 7'h15; cur_hour = 6'h08;
    cur_month = 5'h06; cur_date = 6'h21;
    tcfg = tw(7'h30, 1, 7'h00, 0, 6'h00, 0, 0);
    tag = "R3"; idle(3);
    pulse_tick("R3");
    cur_sec = 7'h31; pulse_tick("R3");
    // R3: back-to-back ticks, each matching second gives its own strobe
    cur_sec = 7'h30;
    tag = "R3"; sec_tick = 1'b1; idle(2); sec_tick = 1'b0; idle(2);

    // R4: nothing enabled, field values equal current
    tcfg = tw(7'h30, 0, 7'h15, 0, 6'h08, 0, 0);
    dcfg = dw(5'h06, 0, 6'h21, 0);
    pulse_tick("R4");

    // R2: every field enabled and matching, then each field off by one
    tcfg = tw(7'h30, 1, 7'h15, 1, 6'h08, 0, 1);
    dcfg = dw(5'h06, 1, 6'h21, 1);
    pulse_tick("R2");
    cur_min = 7'h16; pulse_tick("R2"); cur_min = 7'h15;
    cur_hour = 6'h09; pulse_tick("R2"); cur_hour = 6'h08;
    cur_month = 5'h07; pulse_tick("R2"); cur_month = 5'h06;
    cur_date = 6'h22; pulse_tick("R2"); cur_date = 6'h21;
    // upper unused bits set: no effect
    tcfg[31:24] = 8'hFF; dcfg[15:0] = 16'hFFFF; dcfg[22:21] = 2'b11; dcfg[30] = 1'b1;
    pulse_tick("R2");

    // R5: disabled minute field mismatches, alarm still fires
    tcfg = tw(7'h30, 1, 7'h44, 0, 6'h08, 0, 1);
    dcfg = dw(5'h01, 0, 6'h21, 1);
    pulse_tick("R5");

    // R6: 12-hour mode, AM/PM must agree
    mode_12h = 1'b1;
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h08, 1, 1);
    dcfg = '0;
    cur_pm = 1'b0; pulse_tick("R6");
    cur_pm = 1'b1; pulse_tick("R6");
    // R6: 24-hour mode ignores AM/PM
    mode_12h = 1'b0;
    cur_pm = 1'b0; pulse_tick("R6");

    // R7: seconds and minutes legality
    tcfg = tw(7'h5A, 1, 7'h00, 0, 6'h00, 0, 0); tag = "R7"; idle(2);
    tcfg = tw(7'h60, 1, 7'h00, 0, 6'h00, 0, 0); idle(2);
    tcfg = tw(7'h59, 1, 7'h59, 1, 6'h00, 0, 0); idle(2);
    tcfg = tw(7'h00, 0, 7'h6F, 1, 6'h00, 0, 0); idle(2);

    // R8: hour legality per mode
    tag = "R8";
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h24, 0, 1); idle(2);
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h23, 0, 1); idle(2);
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h00, 0, 1); idle(2);
    mode_12h = 1'b1; idle(2);
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h13, 0, 1); idle(2);
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h12, 0, 1); idle(2);
    tcfg = tw(7'h00, 0, 7'h00, 0, 6'h1A, 0, 1); idle(2);
    mode_12h = 1'b0; tcfg = '0; idle(2);

    // R9: month and day-of-month legality
    tag = "R9";
    dcfg = dw(5'h13, 1, 6'h01, 0); idle(2);
    dcfg = dw(5'h00, 1, 6'h01, 0); idle(2);
    dcfg = dw(5'h12, 1, 6'h31, 1); idle(2);
    dcfg = dw(5'h01, 0, 6'h32, 1); idle(2);
    dcfg = dw(5'h01, 0, 6'h00, 1); idle(2);
    dcfg = dw(5'h01, 0, 6'h1A, 1); idle(2);

    // R11: illegal values in disabled fields raise nothing
    tag = "R11";
    tcfg = tw(7'h7F, 0, 7'h7F, 0, 6'h3F, 1, 0);
    dcfg = dw(5'h1F, 0, 6'h3F, 0); idle(2);
    tcfg = tw(7'h7F, 0, 7'h7F, 0, 6'h3F, 1, 0) | 32'h0000_0080 & 32'h0;
    tcfg[7] = 1'b1; tcfg[6:0] = 7'h30; cur_sec = 7'h30;
    pulse_tick("R11");

    // R10: invalid word blocks a raw match
    cur_date = 6'h00; cur_sec = 7'h30;
    tcfg = tw(7'h30, 1, 7'h00, 0, 6'h00, 0, 0);
    dcfg = dw(5'h00, 0, 6'h00, 1);
    pulse_tick("R10");
    cur_hour = 6'h24;
    tcfg = tw(7'h30, 1, 7'h00, 0, 6'h24, 0, 1); dcfg = '0;
    pulse_tick("R10");
    // writing a legal value releases the block
    cur_hour = 6'h23;
    tcfg = tw(7'h30, 1, 7'h00, 0, 6'h23, 0, 1);
    pulse_tick("R10");

    idle(3);
    // R3: the run must have produced alarms at all
    vectors++;
    if (alarms_expected < 8) begin
      errors++;
      $display("FAIL R3 alarm count actual=%0d expected>=8", alarms_expected);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule